// File: doc/BRIEF.md
# SPI Upload Payload Capture Buffer

This block stores the data bytes that a SPI host sends after a command. The bytes go into a circular memory of 256 entries. The SPI slave front end hands over each received byte with a one-cycle valid strobe. The active-low chip-select frames each transaction. A falling chip-select starts a new command and moves the write position back to entry zero. A rising chip-select closes the transaction.

If the host sends more than 256 bytes, writing carries on around the ring, so the memory always holds the newest 256 bytes. The block raises a one-cycle overflow event in that case. It also keeps the index of the last byte written, which lets software work out where the newest 256-byte window begins. When a transaction closes with at least one byte captured, the block raises a one-cycle not-empty event. Each event sets a sticky status bit, and software clears that bit by writing 1. Software reads the stored bytes through a simple synchronous read port.

Top module: `upl_payload_buf`

## Requirements
- R1: A byte whose valid strobe is sampled while `csN` is low is written at the current write index. The write index is 0 for the first byte after `csN` falls and rises by one per accepted byte. The byte is readable at `rdData` one cycle after `rdAddr` is sampled.
- R2: A valid strobe sampled while `csN` is high is ignored. It changes no memory entry and does not change `lastIdx`.
- R3: `lastIdx` shows the index of the most recently written byte. It keeps that value across later transactions that carry no bytes.
- R4: The write index wraps from 255 to 0. After a payload longer than 256 bytes, entry k holds the newest byte written at index k.
- R5: `evtOverflow` is a one-cycle pulse on the cycle after the 257th byte of a transaction is accepted. It fires at most once per transaction, however long the payload is.
- R6: `evtNotEmpty` is a one-cycle pulse on the cycle after a rising `csN` is sampled, when that transaction accepted at least one byte. It never pulses while bytes are still arriving.
- R7: A transaction that accepts no bytes produces no `evtNotEmpty` pulse.
- R8: Each event sets its sticky status bit (`stsNotEmpty`, `stsOverflow`) on the following edge. A 1 on the matching clear input resets that bit. When an event and a clear arrive on the same edge, the event wins.
- R9: After reset, both events and both status bits are 0 and `lastIdx` is 0.
- R10: A byte accepted on the same edge at which the falling `csN` is first seen is written at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip-select, synchronous to clk |
| byteValid | input | 1 | Received byte strobe from the SPI front end |
| byteData | input | DATA_W | Received payload byte |
| rdAddr | input | ADDR_W | Software read index |
| rdData | output | DATA_W | Stored byte at rdAddr, one cycle later |
| lastIdx | output | ADDR_W | Index of the most recently written byte |
| evtNotEmpty | output | 1 | Pulse: transaction ended with payload captured |
| evtOverflow | output | 1 | Pulse: payload exceeded DEPTH bytes |
| clrNotEmpty | input | 1 | Write-1 clear for stsNotEmpty |
| clrOverflow | input | 1 | Write-1 clear for stsOverflow |
| stsNotEmpty | output | 1 | Sticky not-empty status |
| stsOverflow | output | 1 | Sticky overflow status |

## Verification
The hardest situations to reach from the ports are the exact-cycle ones. The first is the overflow pulse on the 257th byte while the byte counter saturates, with no second pulse later in the same transaction. The second is an event and a clear landing on the same edge. The bench drives long payloads of 257 bytes and up to about 600 bytes, some with random idle gaps, and timestamps each pulse against the cycle in which the triggering byte or chip-select edge was driven. A directed transaction raises the clear strobe in the exact cycle the not-empty pulse is high. Random transaction lengths are mixed with empty transactions, bytes sent while chip-select is high, and a first byte that arrives together with the chip-select fall. After every transaction, all stored entries are read back and compared with a model of the ring.

// File: rtl/upl_pkg.sv
package upl_pkg;
  typedef struct packed {
    logic wrEn;
    logic ptrClr;
  } uplStrb_t;
endpackage

// File: rtl/upl_ctrl.sv
module upl_ctrl
  import upl_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     byteValid,
  input  logic     clrNotEmpty,
  input  logic     clrOverflow,
  output uplStrb_t strb,
  output logic     evtNotEmpty,
  output logic     evtOverflow,
  output logic     stsNotEmpty,
  output logic     stsOverflow
);
  localparam int CNT_W = $clog2(DEPTH + 2);
  localparam logic [CNT_W-1:0] CNT_OVF = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(DEPTH + 1);
  localparam int NUM_EVT = 2;

  logic             csPrev;
  logic             startDet;
  logic             endDet;
  logic             accept;
  logic             ovfHit;
  logic [CNT_W-1:0] byteCnt;

  assign startDet = csPrev & ~csN;
  assign endDet   = ~csPrev & csN;
  assign accept   = byteValid & ~csN;
  assign ovfHit   = accept & ~startDet & (byteCnt == CNT_OVF);

  assign strb.wrEn   = accept;
  assign strb.ptrClr = startDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev <= 1'b1;
    end else begin
      csPrev <= csN;
    end
  end

  // Byte counter saturates at DEPTH+1 so the overflow compare can match only once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (startDet) begin
      byteCnt <= accept ? CNT_W'(1) : '0;
    end else if (accept && (byteCnt != CNT_SAT)) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtNotEmpty <= 1'b0;
      evtOverflow <= 1'b0;
    end else begin
      evtNotEmpty <= endDet && (byteCnt != '0);
      evtOverflow <= ovfHit;
    end
  end

  logic [NUM_EVT-1:0] evtVec;
  logic [NUM_EVT-1:0] clrVec;
  logic [NUM_EVT-1:0] stsVec;

  assign evtVec = {evtOverflow, evtNotEmpty};
  assign clrVec = {clrOverflow, clrNotEmpty};
  assign stsNotEmpty = stsVec[0];
  assign stsOverflow = stsVec[1];

  for (genvar g = 0; g < NUM_EVT; g++) begin : gStatus
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stsVec[g] <= 1'b0;
      end else if (evtVec[g]) begin
        stsVec[g] <= 1'b1;
      end else if (clrVec[g]) begin
        stsVec[g] <= 1'b0;
      end
    end
  end

  // R6
  ne_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtNotEmpty |-> $past(csN));
  // R7
  ne_has_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtNotEmpty |-> ($past(byteCnt) != '0));
  // R5
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtOverflow |=> !evtOverflow);
  // R5
  ovf_on_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtOverflow |-> $past(byteValid && !csN));
  // R8
  sts_ne_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtNotEmpty |=> stsNotEmpty);
  // R8
  sts_ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtOverflow |=> stsOverflow);
endmodule

// File: rtl/upl_dpath.sv
module upl_dpath
  import upl_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  uplStrb_t                 strb,
  input  logic [DATA_W-1:0]        byteData,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [DATA_W-1:0]        rdData,
  output logic [$clog2(DEPTH)-1:0] lastIdx
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] nextPtr;

  assign wrAddr  = strb.ptrClr ? '0 : wrPtr;
  assign nextPtr = (wrAddr == LAST) ? '0 : wrAddr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      lastIdx <= '0;
    end else if (strb.wrEn) begin
      wrPtr   <= nextPtr;
      lastIdx <= wrAddr;
    end else if (strb.ptrClr) begin
      wrPtr   <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      mem[wrAddr] <= byteData;
    end
    rdData <= mem[rdAddr];
  end

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.ptrClr && wrPtr == LAST) |=> (wrPtr == '0));
  // R3
  last_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (lastIdx == $past(wrAddr)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(lastIdx));
  // R10
  start_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.ptrClr) |=> (lastIdx == '0));
endmodule

// File: rtl/upl_payload_buf.sv
module upl_payload_buf
  import upl_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] lastIdx,
  output logic              evtNotEmpty,
  output logic              evtOverflow,
  input  logic              clrNotEmpty,
  input  logic              clrOverflow,
  output logic              stsNotEmpty,
  output logic              stsOverflow
);
  uplStrb_t strb;

  upl_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .byteValid(byteValid),
    .clrNotEmpty(clrNotEmpty), .clrOverflow(clrOverflow), .strb(strb),
    .evtNotEmpty(evtNotEmpty), .evtOverflow(evtOverflow),
    .stsNotEmpty(stsNotEmpty), .stsOverflow(stsOverflow)
  );

  upl_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .rdAddr(rdAddr), .rdData(rdData), .lastIdx(lastIdx)
  );
endmodule

// File: tb/upl_payload_buf_tb_top.sv
`timescale 1ns/1ps
module upl_payload_buf_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [7:0] lastIdx;
  logic       evtNotEmpty, evtOverflow, stsNotEmpty, stsOverflow;
  logic       clrNotEmpty = 1'b0;
  logic       clrOverflow = 1'b0;

  upl_payload_buf dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .byteValid(byteValid), .byteData(byteData),
    .rdAddr(rdAddr), .rdData(rdData), .lastIdx(lastIdx),
    .evtNotEmpty(evtNotEmpty), .evtOverflow(evtOverflow),
    .clrNotEmpty(clrNotEmpty), .clrOverflow(clrOverflow),
    .stsNotEmpty(stsNotEmpty), .stsOverflow(stsOverflow)
  );

  always #10 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int neCnt = 0, ovfCnt = 0, neCyc = 0, ovfCyc = 0;
  logic [7:0] expMem [256];
  bit         wrote [256];
  int         expLast = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (evtNotEmpty) begin neCnt++; neCyc = cyc; end
    if (evtOverflow) begin ovfCnt++; ovfCyc = cyc; end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expNe(int len);
    return (len > 0) ? 1 : 0;
  endfunction

  function automatic int expOvf(int len);
    return (len > 256) ? 1 : 0;
  endfunction

  task automatic checkMem();
    for (int a = 0; a < 256; a++) begin
      if (wrote[a]) begin
        @(negedge clk); rdAddr = 8'(a);
        @(negedge clk);
        chk(rdData == expMem[a], "R1/R4", $sformatf("mem[%0d]", a), rdData, expMem[a]);
      end
    end
  endtask

  task automatic runTxn(int len, bit gaps, bit firstSame, bit clrRace);
    int ovfDrive = -1;
    int endDrive;
    @(negedge clk);
    neCnt = 0; ovfCnt = 0;
    csN = 1'b0; byteValid = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (!(i == 0 && firstSame)) begin
        @(negedge clk);
        if (gaps) begin
          repeat ($urandom_range(0, 2)) begin
            byteValid = 1'b0;
            @(negedge clk);
          end
        end
      end
      byteValid = 1'b1;
      byteData  = 8'($urandom);
      expMem[i % 256] = byteData;
      wrote[i % 256]  = 1'b1;
      expLast = i % 256;
      if (i == 256) ovfDrive = cyc;
    end
    @(negedge clk);
    byteValid = 1'b0; csN = 1'b1; endDrive = cyc;
    chk(neCnt == 0, "R6", "pulse before end", neCnt, 0);
    if (clrRace) begin
      @(negedge clk); clrNotEmpty = 1'b1;
      @(negedge clk); clrNotEmpty = 1'b0;
      chk(stsNotEmpty == 1'b1, "R8", "set wins over clear", stsNotEmpty, 1);
    end
    repeat (4) @(negedge clk);
    chk(neCnt == expNe(len), (len > 0) ? "R6" : "R7", "notEmpty pulses", neCnt, expNe(len));
    chk(ovfCnt == expOvf(len), "R5", "overflow pulses", ovfCnt, expOvf(len));
    if (len > 0) chk(neCyc == endDrive + 1, "R6", "notEmpty cycle", neCyc, endDrive + 1);
    if (len > 256) chk(ovfCyc == ovfDrive + 1, "R5", "overflow cycle", ovfCyc, ovfDrive + 1);
    chk(int'(lastIdx) == expLast, "R3", "lastIdx", lastIdx, expLast);
    chk(int'(stsNotEmpty) == expNe(len), "R8", "stsNotEmpty", stsNotEmpty, expNe(len));
    chk(int'(stsOverflow) == expOvf(len), "R8", "stsOverflow", stsOverflow, expOvf(len));
    clrNotEmpty = 1'b1; clrOverflow = 1'b1;
    @(negedge clk);
    clrNotEmpty = 1'b0; clrOverflow = 1'b0;
    chk(!stsNotEmpty && !stsOverflow, "R8", "clear both", {stsOverflow, stsNotEmpty}, 0);
    checkMem();
  endtask

  task automatic strayBytes(int n);
    neCnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = 8'($urandom);
    end
    @(negedge clk); byteValid = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(lastIdx) == expLast, "R2", "lastIdx after stray", lastIdx, expLast);
    chk(neCnt == 0, "R2", "no event from stray", neCnt, 0);
    checkMem();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 256; a++) wrote[a] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!evtNotEmpty && !evtOverflow, "R9", "events after reset", {evtOverflow, evtNotEmpty}, 0);
    chk(!stsNotEmpty && !stsOverflow, "R9", "status after reset", {stsOverflow, stsNotEmpty}, 0);
    chk(lastIdx == 8'd0, "R9", "lastIdx after reset", lastIdx, 0);

    runTxn(256, 1'b0, 1'b0, 1'b0);   // R1 full fill, no overflow
    runTxn(5, 1'b0, 1'b0, 1'b0);     // R1 restart at index 0
    strayBytes(6);                   // R2
    runTxn(0, 1'b0, 1'b0, 1'b0);     // R7, R3 retention
    runTxn(257, 1'b0, 1'b0, 1'b0);   // R5 exact boundary
    runTxn(600, 1'b1, 1'b0, 1'b0);   // R4 multiple wraps, R5 once
    runTxn(10, 1'b0, 1'b1, 1'b0);    // R10
    runTxn(3, 1'b0, 1'b0, 1'b1);     // R8 set wins
    for (int t = 0; t < 15; t++) begin
      int len = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 520));
      runTxn(len, 1'($urandom), 1'($urandom), 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule